// File: doc/BRIEF.md
# Scatter-Gather Disk Data DMA Engine

This block moves data between system memory and a 16-bit disk-style data stream by walking a list of region descriptors held in memory. Software programs a table base pointer and a transfer direction through a small register port, then raises the run bit. The engine reads each 8-byte descriptor (region address, byte count, last-entry flag), moves that many bytes, and continues with the next descriptor eight bytes further on until the flagged entry is finished.

Direction is seen from the memory side. With the direction bit set, the engine writes to memory: it collects device halfwords into 32-bit memory writes. With it clear, the engine reads from memory and feeds halfwords to the device. The memory port carries one request at a time with a ready/valid handshake and a separate response carrying read data and an error flag. A device interrupt input is latched into a status bit for software.

Top module: `sgdma_engine`

## Requirements
- R1: Register port (byte offsets on `reg_addr_i`): offset 0 is the command register with bit 0 = run and bit 3 = direction, all other bits read 0; offset 2 is status; offset 4 is the table pointer, whose bits 1:0 always read 0. All registers are 0 after reset with default parameters.
- R2: A 0-to-1 change of the run bit sets status bit 0 (active) and starts the engine, whose first two memory reads are at the table pointer and pointer + 4.
- R3: Descriptor word 0 is the region address with bits 1:0 ignored; word 1 holds the byte count in bits 15:0 (bit 0 ignored) and the last-entry flag in bit 31; a count of 0 moves 65536 bytes.
- R4: With direction 1, device halfwords are packed little-endian into 32-bit memory writes (first halfword in bits 15:0), byte enable 4'b1111; a trailing 2-byte word is written with byte enable 4'b0011 and leaves the upper two bytes unchanged.
- R5: With direction 0, each memory word read is sent to the device low half first; a trailing 2-byte word sends only its low half.
- R6: After a region without the last flag, the next descriptor is read at the current descriptor address + 8; after the flagged region, active clears.
- R7: Clearing the run bit stops the engine at the next 32-bit word boundary: the word in progress completes, active clears and no further requests follow.
- R8: A memory response with the error flag sets status bit 1, clears active, and no further memory requests are made.
- R9: A high device interrupt input sets status bit 2; writing 1 to status bit 1 or 2 clears it, writing 0 leaves it.
- R10: Status bits 6:5 (drive DMA capable) are read/write storage, bit 7 reads the simplex parameter, bits 4:3 read 0, and bit 0 is not writable.
- R11: A memory request held without ready keeps its address, write flag and write data stable, and only one request is outstanding.
- R12: When a run finishes with the run bit left at 1, the engine stays idle until the run bit goes 0 and then 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on offset) |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | 32 | Request byte address, word aligned |
| mem_req_wdata_o | output | 32 | Write data |
| mem_req_be_o | output | 4 | Write byte enables |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_rdata_i | input | 32 | Read response data |
| mem_rsp_err_i | input | 1 | Response error flag |
| dev_rx_valid_i | input | 1 | Device-to-host halfword valid |
| dev_rx_data_i | input | 16 | Device-to-host halfword |
| dev_rx_ready_o | output | 1 | Engine accepts a device halfword |
| dev_tx_valid_o | output | 1 | Host-to-device halfword valid |
| dev_tx_data_o | output | 16 | Host-to-device halfword |
| dev_tx_ready_i | input | 1 | Device accepts the halfword |
| dev_irq_i | input | 1 | Device interrupt |

## Verification
Multi-entry tables with region counts of 8, 6 and 2 bytes separate full words from trailing halfwords in both directions, and misaligned region addresses show whether the low address bits are dropped. A single zero-count entry tells 65536 from zero, while randomly sized tables with random memory latency and random device stalls show whether packing order and descriptor chaining survive back-pressure. An error response placed on the second data word, and a run-bit clear in the middle of a long device-to-memory region, tell a clean word-boundary stop from a lost or split word.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned HW = DW / 2;
  localparam int unsigned BEW = DW / 8;

  localparam logic [2:0] OFF_CMD = 3'd0;
  localparam logic [2:0] OFF_STS = 3'd2;
  localparam logic [2:0] OFF_PTR = 3'd4;

  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;
  localparam int unsigned STS_ERR = 1;
  localparam int unsigned STS_IRQ = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_D0_REQ, S_D0_RSP, S_D1_REQ, S_D1_RSP,
    S_GATHER, S_WR_REQ, S_WR_RSP, S_RD_REQ, S_RD_RSP, S_SCATTER
  } eng_state_e;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter logic       SIMPLEX_ONLY = 1'b0,
  parameter logic [1:0] CAP_RST      = 2'b00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          err_set_i,
  input  logic          irq_i,
  output logic          run_o,
  output logic          dir_o,
  output logic          go_o,
  output logic [AW-1:0] ptr_o,
  output logic          sts_err_o,
  output logic          sts_irq_o
);
  logic          run_q, run_d1_q, dir_q, err_q, irq_q;
  logic [1:0]    cap_q;
  logic [AW-3:0] ptr_q;
  logic          wr_cmd, wr_sts, wr_ptr;

  assign wr_cmd = we_i && (addr_i == OFF_CMD);
  assign wr_sts = we_i && (addr_i == OFF_STS);
  assign wr_ptr = we_i && (addr_i == OFF_PTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      run_d1_q <= 1'b0;
      dir_q    <= 1'b0;
      cap_q    <= CAP_RST;
      ptr_q    <= '0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      run_d1_q <= run_q;
      if (wr_cmd) begin
        run_q <= wdata_i[CMD_RUN];
        dir_q <= wdata_i[CMD_DIR];
      end
      if (wr_sts) cap_q <= wdata_i[6:5];
      if (wr_ptr) ptr_q <= wdata_i[AW-1:2];
      // set wins over a same-cycle write-one-to-clear
      if (err_set_i) err_q <= 1'b1;
      else if (wr_sts && wdata_i[STS_ERR]) err_q <= 1'b0;
      if (irq_i) irq_q <= 1'b1;
      else if (wr_sts && wdata_i[STS_IRQ]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CMD: rdata_o[7:0] = {4'b0, dir_q, 2'b0, run_q};
      OFF_STS: rdata_o[7:0] = {SIMPLEX_ONLY, cap_q, 2'b0, irq_q, err_q, busy_i};
      OFF_PTR: rdata_o      = {ptr_q, 2'b00};
      default: rdata_o      = '0;
    endcase
  end

  assign run_o     = run_q;
  assign dir_o     = dir_q;
  assign go_o      = run_q && !run_d1_q;
  assign ptr_o     = {ptr_q, 2'b00};
  assign sts_err_o = err_q;
  assign sts_irq_o = irq_q;
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic           run_i,
  input  logic           dir_i,
  input  logic [AW-1:0]  ptr_i,
  output logic           busy_o,
  output logic           err_o,
  output logic           mem_req_valid_o,
  input  logic           mem_req_ready_i,
  output logic           mem_req_we_o,
  output logic [AW-1:0]  mem_req_addr_o,
  output logic [DW-1:0]  mem_req_wdata_o,
  output logic [BEW-1:0] mem_req_be_o,
  input  logic           mem_rsp_valid_i,
  input  logic [DW-1:0]  mem_rsp_rdata_i,
  input  logic           mem_rsp_err_i,
  input  logic           dev_rx_valid_i,
  input  logic [HW-1:0]  dev_rx_data_i,
  output logic           dev_rx_ready_o,
  output logic           dev_tx_valid_o,
  output logic [HW-1:0]  dev_tx_data_o,
  input  logic           dev_tx_ready_i
);
  localparam int unsigned REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL_CNT = REM_W'(1) << CNT_W;
  localparam logic [AW-1:0] WORD_STEP = AW'(BEW);
  localparam logic [AW-1:0] DESC_STEP = AW'(2 * BEW);

  eng_state_e     state_q, first_word_s, after_word_s;
  logic [AW-1:0]  desc_q, cur_q;
  logic [REM_W-1:0] rem_q, cnt_dec;
  logic [CNT_W-1:0] cnt_raw;
  logic [DW-1:0]  buf_q;
  logic           dir_q, eot_q, half_q;
  logic           two_half, region_end, last_half, in_rsp, rsp_err;

  assign two_half   = rem_q > REM_W'(2);
  assign region_end = rem_q <= REM_W'(4);
  assign last_half  = half_q || !two_half;

  assign cnt_raw = {mem_rsp_rdata_i[CNT_W-1:1], 1'b0};
  assign cnt_dec = (cnt_raw == '0) ? FULL_CNT : {1'b0, cnt_raw};

  assign in_rsp  = (state_q == S_D0_RSP) || (state_q == S_D1_RSP) ||
                   (state_q == S_WR_RSP) || (state_q == S_RD_RSP);
  assign rsp_err = in_rsp && mem_rsp_valid_i && mem_rsp_err_i;

  always_comb begin
    if (!run_i) first_word_s = S_IDLE;
    else if (dir_q) first_word_s = S_GATHER;
    else first_word_s = S_RD_REQ;
  end

  always_comb begin
    if (region_end) after_word_s = eot_q ? S_IDLE : (run_i ? S_D0_REQ : S_IDLE);
    else after_word_s = first_word_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      cur_q   <= '0;
      rem_q   <= '0;
      buf_q   <= '0;
      dir_q   <= 1'b0;
      eot_q   <= 1'b0;
      half_q  <= 1'b0;
    end else if (rsp_err) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (go_i) begin
          desc_q  <= ptr_i;
          dir_q   <= dir_i;
          state_q <= S_D0_REQ;
        end
        S_D0_REQ: if (mem_req_ready_i) state_q <= S_D0_RSP;
        S_D0_RSP: if (mem_rsp_valid_i) begin
          cur_q   <= {mem_rsp_rdata_i[AW-1:2], 2'b00};
          state_q <= S_D1_REQ;
        end
        S_D1_REQ: if (mem_req_ready_i) state_q <= S_D1_RSP;
        S_D1_RSP: if (mem_rsp_valid_i) begin
          rem_q   <= cnt_dec;
          eot_q   <= mem_rsp_rdata_i[DW-1];
          half_q  <= 1'b0;
          state_q <= first_word_s;
        end
        S_GATHER: begin
          if (!half_q && !run_i) begin
            state_q <= S_IDLE;
          end else if (dev_rx_valid_i) begin
            if (half_q) buf_q[DW-1:HW] <= dev_rx_data_i;
            else buf_q[HW-1:0] <= dev_rx_data_i;
            if (last_half) begin
              half_q  <= 1'b0;
              state_q <= S_WR_REQ;
            end else begin
              half_q <= 1'b1;
            end
          end
        end
        S_WR_REQ: if (mem_req_ready_i) state_q <= S_WR_RSP;
        S_RD_REQ: if (mem_req_ready_i) state_q <= S_RD_RSP;
        S_RD_RSP: if (mem_rsp_valid_i) begin
          buf_q   <= mem_rsp_rdata_i;
          half_q  <= 1'b0;
          state_q <= S_SCATTER;
        end
        S_WR_RSP, S_SCATTER: begin
          if ((state_q == S_WR_RSP && mem_rsp_valid_i) ||
              (state_q == S_SCATTER && dev_tx_ready_i && last_half)) begin
            cur_q   <= cur_q + WORD_STEP;
            rem_q   <= rem_q - (two_half ? REM_W'(4) : REM_W'(2));
            half_q  <= 1'b0;
            if (region_end && !eot_q) desc_q <= desc_q + DESC_STEP;
            state_q <= after_word_s;
          end else if (state_q == S_SCATTER && dev_tx_ready_i) begin
            half_q <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != S_IDLE;
  assign err_o  = rsp_err;

  assign mem_req_valid_o = (state_q == S_D0_REQ) || (state_q == S_D1_REQ) ||
                           (state_q == S_WR_REQ) || (state_q == S_RD_REQ);
  assign mem_req_we_o    = state_q == S_WR_REQ;
  assign mem_req_wdata_o = buf_q;
  assign mem_req_be_o    = (state_q == S_WR_REQ && !two_half) ?
                           {{(BEW/2){1'b0}}, {(BEW/2){1'b1}}} : {BEW{1'b1}};

  always_comb begin
    unique case (state_q)
      S_D0_REQ: mem_req_addr_o = desc_q;
      S_D1_REQ: mem_req_addr_o = desc_q + WORD_STEP;
      default:  mem_req_addr_o = cur_q;
    endcase
  end

  assign dev_rx_ready_o = (state_q == S_GATHER) && (half_q || run_i);
  assign dev_tx_valid_o = state_q == S_SCATTER;
  assign dev_tx_data_o  = half_q ? buf_q[DW-1:HW] : buf_q[HW-1:0];
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int unsigned CNT_W        = 16,
  parameter logic        SIMPLEX_ONLY = 1'b0,
  parameter logic [1:0]  CAP_RST      = 2'b00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [31:0]   mem_req_addr_o,
  output logic [31:0]   mem_req_wdata_o,
  output logic [3:0]    mem_req_be_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_rdata_i,
  input  logic          mem_rsp_err_i,
  input  logic          dev_rx_valid_i,
  input  logic [15:0]   dev_rx_data_i,
  output logic          dev_rx_ready_o,
  output logic          dev_tx_valid_o,
  output logic [15:0]   dev_tx_data_o,
  input  logic          dev_tx_ready_i,
  input  logic          dev_irq_i
);
  logic          busy, err_set, run, dir, go, sts_err, sts_irq;
  logic [AW-1:0] ptr;

  sgdma_regs #(
    .SIMPLEX_ONLY(SIMPLEX_ONLY),
    .CAP_RST     (CAP_RST)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .err_set_i (err_set),
    .irq_i     (dev_irq_i),
    .run_o     (run),
    .dir_o     (dir),
    .go_o      (go),
    .ptr_o     (ptr),
    .sts_err_o (sts_err),
    .sts_irq_o (sts_irq)
  );

  sgdma_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .go_i            (go),
    .run_i           (run),
    .dir_i           (dir),
    .ptr_i           (ptr),
    .busy_o          (busy),
    .err_o           (err_set),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_we_o    (mem_req_we_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_wdata_o (mem_req_wdata_o),
    .mem_req_be_o    (mem_req_be_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_rdata_i (mem_rsp_rdata_i),
    .mem_rsp_err_i   (mem_rsp_err_i),
    .dev_rx_valid_i  (dev_rx_valid_i),
    .dev_rx_data_i   (dev_rx_data_i),
    .dev_rx_ready_o  (dev_rx_ready_o),
    .dev_tx_valid_o  (dev_tx_valid_o),
    .dev_tx_data_o   (dev_tx_data_o),
    .dev_tx_ready_i  (dev_tx_ready_i)
  );
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic        mem_req_we_o,
  input logic [31:0] mem_req_addr_o,
  input logic [31:0] mem_req_wdata_o,
  input logic        dev_rx_ready_o,
  input logic        dev_tx_valid_o,
  input logic        dev_irq_i,
  input logic        busy,
  input logic        err_set,
  input logic        sts_err,
  input logic        sts_irq
);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o &&
      $stable(mem_req_addr_o) && $stable(mem_req_we_o) && $stable(mem_req_wdata_o));

  // R8
  err_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set |=> sts_err && !busy);

  // R8
  req_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> busy);

  // R9
  irq_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_irq_i |=> sts_irq);

  // R4
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_rx_ready_o, dev_tx_valid_o}));
endmodule

bind sgdma_engine sgdma_engine_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o),
  .dev_rx_ready_o  (dev_rx_ready_o),
  .dev_tx_valid_o  (dev_tx_valid_o),
  .dev_irq_i       (dev_irq_i),
  .busy            (busy),
  .err_set         (err_set),
  .sts_err         (sts_err),
  .sts_irq         (sts_irq)
);

// File: tb/sgdma_engine_tb.sv
`timescale 1ns/1ps
module sgdma_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        rx_valid = 1'b0, rx_ready;
  logic [15:0] rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [15:0] tx_data;
  logic        irq = 1'b0;

  sgdma_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_req_we_o(mem_req_we),
    .mem_req_addr_o(mem_req_addr), .mem_req_wdata_o(mem_req_wdata), .mem_req_be_o(mem_req_be),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_rdata_i(mem_rsp_rdata), .mem_rsp_err_i(mem_rsp_err),
    .dev_rx_valid_i(rx_valid), .dev_rx_data_i(rx_data), .dev_rx_ready_o(rx_ready),
    .dev_tx_valid_o(tx_valid), .dev_tx_data_o(tx_data), .dev_tx_ready_i(tx_ready),
    .dev_irq_i(irq)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] req_log[$];
  logic [15:0] exp_q[$];
  int tx_cnt, tx_bad, rx_idx, wr_cnt, hold_bad;
  bit fast = 1'b0, rx_en = 1'b0, err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] da [0:7];
  logic [15:0] dc [0:7];
  int nd;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (a < 32'd4096) return mem[a[11:2]];
    return {~a[15:0], a[15:0] ^ 16'h5A5A};
  endfunction

  function automatic logic [15:0] pat(input int i);
    return 16'h3C00 ^ 16'(i * 263);
  endfunction

  function automatic int eff_cnt(input logic [15:0] c);
    return (c == 16'd0) ? 65536 : int'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: one outstanding request, random latency
  initial begin
    int lat;
    bit pend;
    logic [31:0] pa;
    bit pvalid_nr;
    logic [31:0] paddr;
    pend = 1'b0; lat = 0; pa = '0; pvalid_nr = 1'b0; paddr = '0; hold_bad = 0;
    forever begin
      @(posedge clk);
      if (pvalid_nr && (!mem_req_valid || mem_req_addr != paddr)) hold_bad++;
      pvalid_nr = mem_req_valid && !mem_req_ready;
      paddr = mem_req_addr;
      mem_rsp_valid <= 1'b0;
      mem_rsp_err <= 1'b0;
      if (!pend && mem_req_valid && mem_req_ready) begin
        if (pend) hold_bad++;
        pend = 1'b1;
        pa = mem_req_addr;
        lat = fast ? 0 : int'($urandom_range(0, 3));
        req_log.push_back(mem_req_addr);
        if (mem_req_we) begin
          wr_cnt++;
          if (mem_req_addr < 32'd4096)
            for (int b = 0; b < 4; b++)
              if (mem_req_be[b]) mem[mem_req_addr[11:2]][8*b +: 8] = mem_req_wdata[8*b +: 8];
        end
      end else if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= rd(pa);
          mem_rsp_err <= err_en && (pa == err_addr);
          pend = 1'b0;
        end else lat--;
      end
      mem_req_ready <= !pend && (fast || ($urandom % 4 != 0));
    end
  end

  // device source and sink
  initial begin
    forever begin
      @(posedge clk);
      if (rx_valid && rx_ready) rx_idx++;
      rx_valid <= rx_en && ($urandom % 3 != 0);
      rx_data <= pat(rx_idx);
      if (tx_valid && tx_ready) begin
        tx_cnt++;
        if (exp_q.size() == 0) tx_bad++;
        else if (exp_q.pop_front() != tx_data) tx_bad++;
      end
      tx_ready <= fast || ($urandom % 3 != 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 150000; i++) begin
      reg_rd(3'd2, s);
      if (!s[0]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic put_table(input logic [31:0] tbl);
    for (int k = 0; k < nd; k++) begin
      mem[(tbl >> 2) + 2*k]     = da[k];
      mem[(tbl >> 2) + 2*k + 1] = {(k == nd - 1), 15'b0, dc[k]};
    end
  endtask

  task automatic build_tx;
    exp_q.delete();
    for (int k = 0; k < nd; k++) begin
      logic [31:0] base = {da[k][31:2], 2'b00};
      for (int b = 0; b < eff_cnt(dc[k]) / 2; b++) begin
        logic [31:0] a = base + 32'(2 * b);
        logic [31:0] w = rd({a[31:2], 2'b00});
        exp_q.push_back(a[1] ? w[31:16] : w[15:0]);
      end
    end
  endtask

  task automatic check_log(input logic [31:0] tbl, input string req);
    logic [31:0] e[$];
    int bad = 0;
    for (int k = 0; k < nd; k++) begin
      e.push_back(tbl + 32'(8 * k));
      e.push_back(tbl + 32'(8 * k + 4));
      for (int w = 0; w < (eff_cnt(dc[k]) + 3) / 4; w++)
        e.push_back({da[k][31:2], 2'b00} + 32'(4 * w));
    end
    if (e.size() != req_log.size()) bad++;
    else foreach (e[i]) if (e[i] != req_log[i]) bad++;
    chk(bad == 0, req, "request address sequence", 32'(req_log.size()), 32'(e.size()));
  endtask

  task automatic check_gather(input string req);
    int bad = 0, idx = 0, tail_bad = 0;
    for (int k = 0; k < nd; k++) begin
      logic [31:0] base = {da[k][31:2], 2'b00};
      int c = eff_cnt(dc[k]);
      for (int b = 0; b < c / 2; b++) begin
        logic [31:0] a = base + 32'(2 * b);
        logic [31:0] w = mem[a[11:2]];
        if ((a[1] ? w[31:16] : w[15:0]) != pat(idx)) bad++;
        idx++;
      end
      if (c % 4 == 2) begin
        logic [31:0] a = base + 32'(c - 2);
        if (mem[a[11:2]][31:16] != 16'hDEAD) tail_bad++;
      end
    end
    chk(bad == 0, req, "gathered halfwords in memory", 32'(bad), 0);
    chk(tail_bad == 0, "R4", "trailing upper half untouched", 32'(tail_bad), 0);
    chk(rx_idx == idx, req, "device halfwords consumed", 32'(rx_idx), 32'(idx));
  endtask

  task automatic start_run(input logic [31:0] tbl, input bit dir);
    req_log.delete();
    tx_cnt = 0; tx_bad = 0; rx_idx = 0; wr_cnt = 0;
    rx_en = dir;
    reg_wr(3'd4, tbl);
    reg_wr(3'd0, {28'b0, dir, 3'b000});
    reg_wr(3'd0, {28'b0, dir, 3'b001});
  endtask

  task automatic stop_run(input bit dir);
    reg_wr(3'd0, {28'b0, dir, 3'b000});
    rx_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    int n0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 1024; i++) mem[i] = 32'(i * 32'h01010101) ^ 32'h13579BDF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(3'd0, v); chk(v == 0, "R1", "command after reset", v, 0);
    reg_rd(3'd2, v); chk(v == 0, "R1", "status after reset", v, 0);
    reg_rd(3'd4, v); chk(v == 0, "R1", "pointer after reset", v, 0);
    chk(mem_req_valid == 0, "R1", "no request after reset", 32'(mem_req_valid), 0);

    // register map
    reg_wr(3'd4, 32'h0000_0123);
    reg_rd(3'd4, v); chk(v == 32'h0000_0120, "R1", "pointer low bits", v, 32'h120);
    reg_wr(3'd0, 32'hF6);
    reg_rd(3'd0, v); chk(v == 0, "R1", "command unused bits", v, 0);
    reg_wr(3'd0, 32'h08);
    reg_rd(3'd0, v); chk(v == 32'h08, "R1", "direction bit", v, 32'h08);
    reg_wr(3'd0, 32'h00);
    reg_wr(3'd2, 32'h60);
    reg_rd(3'd2, v); chk(v == 32'h60, "R10", "capability bits", v, 32'h60);
    reg_wr(3'd2, 32'hFF);
    reg_rd(3'd2, v); chk(v == 32'h60, "R10", "status write all ones", v, 32'h60);
    reg_wr(3'd2, 32'h00);
    reg_rd(3'd2, v); chk(v == 0, "R10", "capability cleared", v, 0);

    // interrupt latch and write-one-to-clear
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
    reg_rd(3'd2, v); chk(v[2] == 1'b1, "R9", "interrupt latched", v, 32'h4);
    reg_wr(3'd2, 32'h00);
    reg_rd(3'd2, v); chk(v[2] == 1'b1, "R9", "write 0 keeps interrupt", v, 32'h4);
    reg_wr(3'd2, 32'h04);
    reg_rd(3'd2, v); chk(v[2] == 1'b0, "R9", "write 1 clears interrupt", v, 0);

    // memory to device, three chained regions
    nd = 3;
    da[0] = 32'h200; dc[0] = 16'd8;
    da[1] = 32'h301; dc[1] = 16'd6;
    da[2] = 32'h400; dc[2] = 16'd2;
    put_table(32'h100); build_tx();
    start_run(32'h100, 1'b0);
    repeat (3) @(negedge clk);
    reg_rd(3'd2, v); chk(v[0] == 1'b1, "R2", "active after run rise", v, 1);
    wait_idle(ok); chk(ok, "R6", "active clears after last region", 32'(ok), 1);
    chk(tx_cnt == 8 && tx_bad == 0, "R5", "device halfword stream", 32'(tx_bad), 0);
    chk(req_log.size() > 1 && req_log[0] == 32'h100 && req_log[1] == 32'h104, "R2",
        "first descriptor reads", req_log.size() > 0 ? req_log[0] : 0, 32'h100);
    check_log(32'h100, "R6");
    chk(hold_bad == 0, "R11", "request stable until ready", 32'(hold_bad), 0);

    // run bit left high: no restart
    n0 = req_log.size();
    repeat (40) @(negedge clk);
    reg_rd(3'd2, v);
    chk(v[0] == 1'b0 && req_log.size() == n0, "R12", "idle with run held", 32'(req_log.size()), 32'(n0));
    stop_run(1'b0);

    // device to memory, full words plus trailing halfword
    nd = 2;
    da[0] = 32'h600; dc[0] = 16'd10;
    da[1] = 32'h702; dc[1] = 16'd4;
    for (int i = 0; i < 8; i++) begin mem[(32'h600 >> 2) + i] = 32'hDEADBEEF; mem[(32'h700 >> 2) + i] = 32'hDEADBEEF; end
    put_table(32'h180);
    start_run(32'h180, 1'b1);
    wait_idle(ok); chk(ok, "R6", "gather run completes", 32'(ok), 1);
    check_gather("R4");
    chk(wr_cnt == 4, "R4", "memory write count", 32'(wr_cnt), 4);
    stop_run(1'b1);

    // constrained random tables
    for (int it = 0; it < 4; it++) begin
      bit dir = 1'($urandom % 2);
      nd = int'($urandom_range(1, 3));
      for (int k = 0; k < nd; k++) begin
        da[k] = 32'hA00 + 32'(k * 32'h100) + 32'($urandom % 4);
        dc[k] = 16'(2 * $urandom_range(1, 30));
        for (int i = 0; i < 64; i++) mem[(32'hA00 >> 2) + k * 64 + i] = dir ? 32'hDEADBEEF : $urandom;
      end
      put_table(32'h800);
      if (!dir) build_tx();
      start_run(32'h800, dir);
      wait_idle(ok); chk(ok, "R6", "random run completes", 32'(ok), 1);
      if (dir) check_gather("R4");
      else begin
        chk(tx_bad == 0 && exp_q.size() == 0, "R5", "random device stream", 32'(tx_bad), 0);
        check_log(32'h800, "R3");
      end
      stop_run(dir);
    end

    // zero count means 65536 bytes
    fast = 1'b1;
    nd = 1; da[0] = 32'h0001_0000; dc[0] = 16'd0;
    put_table(32'h1A0); build_tx();
    start_run(32'h1A0, 1'b0);
    wait_idle(ok);
    chk(tx_cnt == 32768 && tx_bad == 0, "R3", "zero count halfwords", 32'(tx_cnt), 32768);
    stop_run(1'b0);
    fast = 1'b0;

    // error response on the second data word
    nd = 1; da[0] = 32'h500; dc[0] = 16'd16;
    put_table(32'h1C0); build_tx();
    err_en = 1'b1; err_addr = 32'h504;
    start_run(32'h1C0, 1'b0);
    wait_idle(ok);
    repeat (30) @(negedge clk);
    reg_rd(3'd2, v);
    chk(v[1] == 1'b1 && v[0] == 1'b0, "R8", "error set, active clear", v, 32'h2);
    chk(req_log.size() == 4 && req_log[3] == 32'h504, "R8", "no request after error",
        32'(req_log.size()), 4);
    chk(tx_cnt == 2, "R8", "halfwords before error", 32'(tx_cnt), 2);
    err_en = 1'b0;
    reg_wr(3'd2, 32'h00);
    reg_rd(3'd2, v); chk(v[1] == 1'b1, "R9", "write 0 keeps error", v, 32'h2);
    reg_wr(3'd2, 32'h02);
    reg_rd(3'd2, v); chk(v[1] == 1'b0, "R9", "write 1 clears error", v, 0);
    stop_run(1'b0);

    // abort mid region
    nd = 1; da[0] = 32'hE00; dc[0] = 16'd64;
    put_table(32'h1E0);
    start_run(32'h1E0, 1'b1);
    repeat (40) @(negedge clk);
    reg_wr(3'd0, 32'h08);
    wait_idle(ok); chk(ok, "R7", "abort clears active", 32'(ok), 1);
    n0 = req_log.size();
    repeat (30) @(negedge clk);
    chk(req_log.size() == n0, "R7", "no requests after abort", 32'(req_log.size()), 32'(n0));
    chk(rx_idx % 2 == 0 && wr_cnt == rx_idx / 2 && rx_idx < 32, "R7", "stop on word boundary",
        32'(rx_idx), 32'(2 * wr_cnt));
    rx_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule